// File: doc/BRIEF.md
# DMA Chain Descriptor Fetch Engine

This block walks a linked list of transfer descriptors held in local memory. Each descriptor is an eight-word record. The block reads the record one word at a time over a word-wide memory read port and latches every word into its own working register. It then gives a single-cycle start pulse to a downstream data mover. When the mover reports that it has finished, the block can write a status byte back into the descriptor's byte-count word. After that it follows the record's next pointer, or it stops and signals done.

Software starts a chain by presenting the address of the first descriptor together with a start pulse. The working registers stay visible on dedicated outputs for the data mover. They include the control word, the third word (a CRC address or fill pattern, depending on the mode), the byte count and the destination and source address pairs. The mover reads its configuration from these outputs while it runs.

Top module: `dma_desc_fetch`

## Requirements
- R1: Word k of a descriptor (k = 0..7) is latched as follows. Word 0 goes to `desc_next_o` and word 1 to `desc_ctrl_o`. Word 2 goes to `desc_aux_o` and word 3 to `desc_cnt_o`, whose byte count is bits 23:0. Words 4 and 5 go to `desc_dst_o` as low half then high half, and words 6 and 7 go to `desc_src_o` the same way. All eight values are valid when `mv_start_o` is high.
- R2: The eight words of a descriptor are requested one at a time, at byte addresses base+0, +4, …, +28, in ascending order. A request is accepted when `rd_valid_o` and `rd_ready_i` are both high, and its data is taken on the next cycle that has `rd_rvalid_i` high. While the request waits for `rd_ready_i`, the address is held.
- R3: The base address of a descriptor is the supplied pointer with bits 4:0 forced to zero. This applies both to the first address and to every next pointer.
- R4: After the eighth word is latched, `mv_start_o` is high for exactly one cycle. This happens once per descriptor.
- R5: When the mover raises `mv_done_i`, the block checks bit 0 of the control word. If that bit is 1, it writes one word to base+12 with data {`mv_status_i`, loaded byte count[23:0]}, and the write is held until `wr_ready_i`. If the bit is 0, no write takes place.
- R6: A descriptor whose next pointer has a non-zero value in bits 31:5 is followed by a fetch of the descriptor at that pointer.
- R7: A descriptor whose next pointer has bits 31:5 all zero ends the chain. After its mover completion, and after its write-back if one is enabled, `done_o` is high for one cycle, and from that cycle on `busy_o` is low.
- R8: A start pulse whose address has bits 31:5 all zero is ignored. No read is issued, `busy_o` stays low and `done_o` is not raised.
- R9: `busy_o` is high from the cycle after an accepted start until the end of the chain.
- R10: A start pulse that arrives while `busy_o` is high has no effect on the sequence of reads or writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a chain at first_addr_i |
| first_addr_i | input | 32 | Address of the first descriptor |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | 32 | Read byte address |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_rdata_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Status write-back valid |
| wr_ready_i | input | 1 | Write accepted |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Write data |
| mv_start_o | output | 1 | Start pulse to the data mover |
| mv_done_i | input | 1 | Mover completion pulse |
| mv_status_i | input | 8 | Status byte from the mover |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | Chain finished pulse |
| desc_next_o | output | 32 | Loaded next pointer word |
| desc_ctrl_o | output | 32 | Loaded control word |
| desc_aux_o | output | 32 | Loaded CRC address or fill pattern |
| desc_cnt_o | output | 32 | Loaded byte-count word |
| desc_dst_o | output | 64 | Loaded destination address {high, low} |
| desc_src_o | output | 64 | Loaded source-0 address {high, low} |

## Verification
The bench sweeps the read-accept stall over 0 to 2 cycles and the read-data latency over 0 to 2 cycles, and it varies the write-accept stall and the mover latency along with them. Each setting runs a three-descriptor chain with unaligned first and next pointers and a mix of write-back enables. The sweep shows that word latching and address stepping do not depend on handshake timing, and that both the write-back and the skip of the write-back follow the control bit. A single-descriptor chain, whose next pointer is non-zero only in bits 4:0, separates end detection on the aligned pointer from end detection on the raw value. Start pulses with zero-like addresses, and a second start pulse in the middle of a chain, confirm the cases where start must be ignored.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int unsigned NW    = 8;
  localparam int unsigned IDX_W = $clog2(NW);

  // word order inside a descriptor record
  localparam int unsigned W_NEXT   = 0;
  localparam int unsigned W_CTRL   = 1;
  localparam int unsigned W_AUX    = 2;
  localparam int unsigned W_COUNT  = 3;
  localparam int unsigned W_DST_LO = 4;
  localparam int unsigned W_DST_HI = 5;
  localparam int unsigned W_SRC_LO = 6;
  localparam int unsigned W_SRC_HI = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RESP,
    ST_KICK,
    ST_RUN,
    ST_WB
  } fetch_state_e;
endpackage

// File: rtl/desc_regs.sv
module desc_regs #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NWD   = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NWD-1:0][DW-1:0]   words_o
);
  for (genvar g = 0; g < NWD; g++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (we_i && idx_i == IDX_W'(g))      q <= wdata_i;
    end
    assign words_o[g] = q;
  end
endmodule

// File: rtl/desc_ctrl.sv
module desc_ctrl
  import dma_desc_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned LG     = 2,
  parameter int unsigned OFS_W  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [AW-1:0]       first_addr_i,
  output logic                rd_valid_o,
  input  logic                rd_ready_i,
  output logic [AW-1:0]       rd_addr_o,
  input  logic                rd_rvalid_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [AW-1:0]       wr_addr_o,
  output logic [DW-1:0]       wr_data_o,
  output logic                mv_start_o,
  input  logic                mv_done_i,
  input  logic [DW-CNT_W-1:0] mv_status_i,
  input  logic [AW-1:0]       next_i,
  input  logic                wb_en_i,
  input  logic [CNT_W-1:0]    count_i,
  output logic                ld_en_o,
  output logic [IDX_W-1:0]    ld_idx_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam logic [AW-1:0] ALIGN_MASK = {{(AW-OFS_W){1'b1}}, {OFS_W{1'b0}}};
  localparam logic [AW-1:0] CNT_OFS    = AW'(W_COUNT) << LG;

  fetch_state_e            state_q;
  logic [AW-1:0]           base_q;
  logic [IDX_W-1:0]        idx_q;
  logic [DW-CNT_W-1:0]     stat_q;
  logic                    done_q;
  logic [AW-1:0]           first_al, next_al;
  logic                    fin;

  assign first_al = first_addr_i & ALIGN_MASK;
  assign next_al  = next_i & ALIGN_MASK;
  assign fin = (state_q == ST_RUN && mv_done_i && !wb_en_i) ||
               (state_q == ST_WB && wr_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      stat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i && first_al != '0) begin
          base_q  <= first_al;
          idx_q   <= '0;
          state_q <= ST_REQ;
        end
        ST_REQ:  if (rd_ready_i) state_q <= ST_RESP;
        ST_RESP: if (rd_rvalid_i) begin
          if (idx_q == IDX_W'(NW - 1)) state_q <= ST_KICK;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_KICK: state_q <= ST_RUN;
        ST_RUN:  if (mv_done_i) begin
          stat_q <= mv_status_i;
          if (wb_en_i) state_q <= ST_WB;
        end
        ST_WB: ;
        default: state_q <= ST_IDLE;
      endcase
      // completion of a descriptor: follow pointer or end chain
      if (fin) begin
        if (next_al != '0) begin
          base_q  <= next_al;
          idx_q   <= '0;
          state_q <= ST_REQ;
        end else begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign rd_valid_o = (state_q == ST_REQ);
  assign rd_addr_o  = base_q | (AW'(idx_q) << LG);
  assign ld_en_o    = (state_q == ST_RESP) && rd_rvalid_i;
  assign ld_idx_o   = idx_q;
  assign mv_start_o = (state_q == ST_KICK);
  assign wr_valid_o = (state_q == ST_WB);
  assign wr_addr_o  = base_q | CNT_OFS;
  assign wr_data_o  = {stat_q, count_i};
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_desc_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned WB_BIT = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [AW-1:0]       first_addr_i,
  output logic                rd_valid_o,
  input  logic                rd_ready_i,
  output logic [AW-1:0]       rd_addr_o,
  input  logic                rd_rvalid_i,
  input  logic [DW-1:0]       rd_rdata_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [AW-1:0]       wr_addr_o,
  output logic [DW-1:0]       wr_data_o,
  output logic                mv_start_o,
  input  logic                mv_done_i,
  input  logic [DW-CNT_W-1:0] mv_status_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DW-1:0]       desc_next_o,
  output logic [DW-1:0]       desc_ctrl_o,
  output logic [DW-1:0]       desc_aux_o,
  output logic [DW-1:0]       desc_cnt_o,
  output logic [2*DW-1:0]     desc_dst_o,
  output logic [2*DW-1:0]     desc_src_o
);
  localparam int unsigned LG    = $clog2(DW / 8);
  localparam int unsigned OFS_W = $clog2(NW * DW / 8);

  logic [NW-1:0][DW-1:0] words;
  logic                  ld_en;
  logic [IDX_W-1:0]      ld_idx;

  desc_regs #(.DW(DW), .NWD(NW), .IDX_W(IDX_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ld_en),
    .idx_i   (ld_idx),
    .wdata_i (rd_rdata_i),
    .words_o (words)
  );

  desc_ctrl #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .LG(LG), .OFS_W(OFS_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .first_addr_i (first_addr_i),
    .rd_valid_o   (rd_valid_o),
    .rd_ready_i   (rd_ready_i),
    .rd_addr_o    (rd_addr_o),
    .rd_rvalid_i  (rd_rvalid_i),
    .wr_valid_o   (wr_valid_o),
    .wr_ready_i   (wr_ready_i),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .mv_start_o   (mv_start_o),
    .mv_done_i    (mv_done_i),
    .mv_status_i  (mv_status_i),
    .next_i       (words[W_NEXT][AW-1:0]),
    .wb_en_i      (words[W_CTRL][WB_BIT]),
    .count_i      (words[W_COUNT][CNT_W-1:0]),
    .ld_en_o      (ld_en),
    .ld_idx_o     (ld_idx),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  assign desc_next_o = words[W_NEXT];
  assign desc_ctrl_o = words[W_CTRL];
  assign desc_aux_o  = words[W_AUX];
  assign desc_cnt_o  = words[W_COUNT];
  assign desc_dst_o  = {words[W_DST_HI], words[W_DST_LO]};
  assign desc_src_o  = {words[W_SRC_HI], words[W_SRC_LO]};
endmodule

// File: rtl/desc_fetch_chk.sv
module desc_fetch_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          mv_start_o,
  input logic          busy_o,
  input logic          done_o
);
  localparam int unsigned OFS_W = $clog2(8 * DW / 8);
  localparam logic [OFS_W-1:0] CNT_OFS = OFS_W'(3 * (DW / 8));

  a_r2_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  a_r4_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_start_o |=> !mv_start_o);

  a_r5_wb_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_addr_o[OFS_W-1:0] == CNT_OFS);

  a_r5_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_busy_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o || wr_valid_o || mv_start_o) |-> busy_o);
endmodule

bind dma_desc_fetch desc_fetch_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .mv_start_o (mv_start_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_dma_desc_fetch.sv
`timescale 1ns/1ps
module test_dma_desc_fetch;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [31:0]   first_addr_i = '0;
  logic          rd_valid_o, rd_ready_i = 1'b0;
  logic [31:0]   rd_addr_o;
  logic          rd_rvalid_i = 1'b0;
  logic [31:0]   rd_rdata_i = '0;
  logic          wr_valid_o, wr_ready_i = 1'b0;
  logic [31:0]   wr_addr_o, wr_data_o;
  logic          mv_start_o, mv_done_i = 1'b0;
  logic [7:0]    mv_status_i = '0;
  logic          busy_o, done_o;
  logic [31:0]   desc_next_o, desc_ctrl_o, desc_aux_o, desc_cnt_o;
  logic [63:0]   desc_dst_o, desc_src_o;

  dma_desc_fetch i_dma_desc_fetch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .first_addr_i(first_addr_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .mv_start_o(mv_start_o), .mv_done_i(mv_done_i),
    .mv_status_i(mv_status_i), .busy_o(busy_o), .done_o(done_o),
    .desc_next_o(desc_next_o), .desc_ctrl_o(desc_ctrl_o), .desc_aux_o(desc_aux_o),
    .desc_cnt_o(desc_cnt_o), .desc_dst_o(desc_dst_o), .desc_src_o(desc_src_o)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [31:0] mem [0:255];

  // run-time knobs and logs
  int rstall = 0, rlat = 0, wstall = 0, mlat = 0;
  logic [31:0] rd_log [0:63];
  logic [31:0] wa_log [0:15];
  logic [31:0] wd_log [0:15];
  int rd_n = 0, wr_n = 0, start_n = 0, done_cnt = 0, busy_gap = 0, poke_hits = 0;
  bit in_run = 1'b0;
  logic [31:0] exp_rd [0:63];
  logic [31:0] exp_wa [0:15];
  logic [31:0] exp_wd [0:15];
  logic [31:0] exp_base [0:15];
  int exp_rn, exp_wn, exp_dn;

  function automatic logic [7:0] stat_of(input int i);
    return 8'hA0 + 8'(i);
  endfunction

  // read port responder
  initial begin
    bit hs = 1'b0;
    logic [31:0] aq = '0;
    int rc = 0, sc = 0;
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      rd_rvalid_i = 1'b0;
      if (hs) begin hs = 1'b0; pend = 1'b1; rc = rlat; end
      if (pend) begin
        if (rc == 0) begin
          rd_rvalid_i = 1'b1;
          rd_rdata_i = mem[aq[9:2]];
          pend = 1'b0;
        end else rc--;
      end
      if (rd_valid_o) begin
        if (sc <= 0) begin
          rd_ready_i = 1'b1;
          hs = 1'b1;
          aq = rd_addr_o;
          if (rd_n < 64) rd_log[rd_n] = rd_addr_o;
          rd_n++;
          if (rd_addr_o[31:5] == 27'(32'h2C0 >> 5)) poke_hits++;
          sc = rstall;
        end else begin
          rd_ready_i = 1'b0;
          sc--;
        end
      end else rd_ready_i = 1'b0;
    end
  end

  // write port responder
  initial begin
    int sc = 0;
    forever begin
      @(negedge clk);
      if (wr_valid_o) begin
        if (sc <= 0) begin
          wr_ready_i = 1'b1;
          if (wr_n < 16) begin wa_log[wr_n] = wr_addr_o; wd_log[wr_n] = wr_data_o; end
          wr_n++;
          sc = wstall;
        end else begin
          wr_ready_i = 1'b0;
          sc--;
        end
      end else wr_ready_i = 1'b0;
    end
  end

  // data mover model, checks loaded registers at each start (R1)
  initial begin
    int mc = 0;
    bit mp = 1'b0;
    forever begin
      @(negedge clk);
      mv_done_i = 1'b0;
      if (mv_start_o) begin
        logic [31:0] b;
        b = exp_base[start_n % 16];
        check({desc_next_o, desc_ctrl_o} == {mem[b[9:2]], mem[b[9:2]+1]},
              "R1 next/ctrl", {desc_next_o, desc_ctrl_o}, {mem[b[9:2]], mem[b[9:2]+1]});
        check({desc_aux_o, desc_cnt_o} == {mem[b[9:2]+2], mem[b[9:2]+3]},
              "R1 aux/count", {desc_aux_o, desc_cnt_o}, {mem[b[9:2]+2], mem[b[9:2]+3]});
        check(desc_dst_o == {mem[b[9:2]+5], mem[b[9:2]+4]}, "R1 dst",
              desc_dst_o, {mem[b[9:2]+5], mem[b[9:2]+4]});
        check(desc_src_o == {mem[b[9:2]+7], mem[b[9:2]+6]}, "R1 src",
              desc_src_o, {mem[b[9:2]+7], mem[b[9:2]+6]});
        start_n++;
        mc = mlat;
        mp = 1'b1;
      end else if (mp) begin
        if (mc == 0) begin
          mv_done_i = 1'b1;
          mv_status_i = stat_of(start_n - 1);
          mp = 1'b0;
        end else mc--;
      end
    end
  end

  // done and busy monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin done_cnt++; in_run = 1'b0; end
      else if (in_run && !busy_o) busy_gap++;
    end
  end

  task automatic put_desc(input int d, input logic [31:0] b, input logic [31:0] nxt,
                          input bit wb);
    int w;
    w = int'(b[9:2]);
    mem[w]   = nxt;
    mem[w+1] = 32'h0A50_0000 | (32'(d) << 8) | 32'(wb);
    mem[w+2] = 32'h2000_0000 | (32'(d) << 4);
    mem[w+3] = 32'hEE00_0123 | (32'(d) << 16);
    for (int k = 4; k < 8; k++) mem[w+k] = 32'h5000_0000 | (32'(d) << 12) | (32'(k) << 4);
  endtask

  // expected traffic derived from memory contents
  task automatic expect_chain(input logic [31:0] first);
    logic [31:0] b, nx;
    exp_rn = 0; exp_wn = 0; exp_dn = 0;
    b = first & 32'hFFFF_FFE0;
    for (int g = 0; g < 16; g++) begin
      exp_base[exp_dn] = b;
      for (int k = 0; k < 8; k++) begin exp_rd[exp_rn] = b + 32'(4 * k); exp_rn++; end
      if (mem[b[9:2]+1][0]) begin
        exp_wa[exp_wn] = b + 32'd12;
        exp_wd[exp_wn] = {stat_of(exp_dn), mem[b[9:2]+3][23:0]};
        exp_wn++;
      end
      exp_dn++;
      nx = mem[b[9:2]];
      if (nx[31:5] == '0) break;
      b = nx & 32'hFFFF_FFE0;
    end
  endtask

  task automatic run(input logic [31:0] first, input int rs, input int rl,
                     input int ws, input int ml, input bit poke, input string tag);
    int c, bad;
    rstall = rs; rlat = rl; wstall = ws; mlat = ml;
    rd_n = 0; wr_n = 0; start_n = 0; done_cnt = 0; busy_gap = 0; poke_hits = 0;
    expect_chain(first);
    @(negedge clk);
    start_i = 1'b1; first_addr_i = first;
    @(negedge clk);
    start_i = 1'b0;
    in_run = 1'b1;
    c = 0;
    while (done_cnt == 0 && c < 3000) begin
      @(negedge clk);
      c++;
      if (poke && c == 20) begin start_i = 1'b1; first_addr_i = 32'h2C0; end
      if (poke && c == 21) start_i = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(done_cnt == 1, {"R7 done count ", tag}, 64'(done_cnt), 64'd1);
    check(!busy_o, {"R7 idle after done ", tag}, 64'(busy_o), 64'd0);
    check(busy_gap == 0, {"R9 busy gap ", tag}, 64'(busy_gap), 64'd0);
    bad = (rd_n == exp_rn) ? 0 : 1;
    for (int i = 0; i < exp_rn && i < rd_n; i++) if (rd_log[i] != exp_rd[i]) bad++;
    check(bad == 0, {"R2 R3 read sequence ", tag}, 64'(rd_n), 64'(exp_rn));
    check(start_n == exp_dn, {"R4 R6 starts ", tag}, 64'(start_n), 64'(exp_dn));
    check(wr_n == exp_wn, {"R5 write count ", tag}, 64'(wr_n), 64'(exp_wn));
    for (int i = 0; i < exp_wn && i < wr_n; i++)
      check({wa_log[i], wd_log[i]} == {exp_wa[i], exp_wd[i]}, {"R5 write-back ", tag},
            {wa_log[i], wd_log[i]}, {exp_wa[i], exp_wd[i]});
    if (poke) check(poke_hits == 0, {"R10 restart ignored ", tag}, 64'(poke_hits), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=timeout expected=chain end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    put_desc(0, 32'h040, 32'h0000_010B, 1'b1);
    put_desc(1, 32'h100, 32'h0000_01B5, 1'b0);
    put_desc(2, 32'h1A0, 32'h0000_0013, 1'b1);
    put_desc(3, 32'h2C0, 32'h0000_001B, 1'b1);

    repeat (3) @(negedge clk);
    check({busy_o, done_o, rd_valid_o, wr_valid_o, mv_start_o} == 5'b0,
          "R9 reset state", 64'({busy_o, done_o, rd_valid_o, wr_valid_o, mv_start_o}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: zero-like start addresses
    rd_n = 0; done_cnt = 0; n = 0;
    for (int a = 0; a < 2; a++) begin
      start_i = 1'b1; first_addr_i = (a == 0) ? 32'h0 : 32'h1C;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (busy_o) n++;
        @(negedge clk);
      end
    end
    check(rd_n == 0, "R8 no read on zero start", 64'(rd_n), 64'd0);
    check(n == 0, "R8 busy stays low", 64'(n), 64'd0);
    check(done_cnt == 0, "R8 no done", 64'(done_cnt), 64'd0);

    // handshake timing sweep over a three-descriptor chain
    for (int rs = 0; rs < 3; rs++)
      for (int rl = 0; rl < 3; rl++)
        run(32'h047, rs, rl, 2 - rs, rl, (rs == 1 && rl == 1), $sformatf("rs%0d rl%0d", rs, rl));

    // single descriptor, next pointer non-zero only below bit 5
    run(32'h2C5, 0, 1, 1, 3, 1'b0, "single");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule